// File: doc/BRIEF.md
# Subtractive Command Decoder

This block turns single command bytes arriving from a host link into latched clock-control settings. Every byte that arrives with its valid strobe has a fixed offset of 0xA9 taken away from it, modulo 256. The 8-bit difference, rather than the raw byte, is split into three control fields. The first is a pair of power enables for two PLLs. The second is a 3-bit select for a first clock multiplexer, which chooses among PLL output frequencies. The third is a 3-bit select for a second multiplexer, which chooses the signal returned to the host.

Only a small set of differences is accepted. One difference requests a device status check: it raises a one-cycle request pulse and leaves the settings alone. Six differences are clock configurations, which are latched. Any other difference is rejected with a one-cycle error pulse, and the latched settings stay as they were. All outputs come from registers and change on the clock edge that samples the strobe.

Top module: `ctl_byte_decoder`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next edge clears `pll_pwr`, `fsel` and `rsel` to zero and drives `status_req` and `cmd_err` low.
- R2: A strobed byte whose difference D = byte − 0xA9 (mod 256) is one of 0x10, 0x12, 0x13, 0x24, 0x26 or 0x27 is a configuration. On the sampling edge it loads `pll_pwr` = {D[5], D[4]}.
- R3: The same configuration edge loads `fsel` = D[2:0]. Bytes 0xB9, 0xBB, 0xBC, 0xCD, 0xCF and 0xD0 give `fsel` values 0, 2, 3, 4, 6 and 7.
- R4: The same configuration edge loads `rsel` = {D[7], D[6], D[3]}, in that order.
- R5: A strobed byte 0xAA (D = 0x01) raises `status_req` for exactly the following cycle and leaves `pll_pwr`, `fsel` and `rsel` unchanged.
- R6: A strobed byte whose difference is neither 0x01 nor a configuration value raises `cmd_err` for exactly the following cycle and leaves `pll_pwr`, `fsel` and `rsel` unchanged.
- R7: A cycle in which `cmd_valid` is low leaves all three control fields unchanged and gives low `status_req` and `cmd_err` after the next edge.
- R8: `status_req` and `cmd_err` are never high in the same cycle. Each falls after one cycle unless a new strobed byte raises it again.
- R9: The subtraction wraps. Bytes below 0xA9 give differences 0x57 to 0xFF, none of which is accepted, so they raise `cmd_err`. Byte 0xA9 itself (D = 0x00) is also rejected.
- R10: When the reset and `cmd_valid` are both high at an edge, the reset wins and the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte from the host link |
| pll_pwr | output | 2 | PLL power enables {D[5], D[4]} |
| fsel | output | 3 | First multiplexer select, frequency choice |
| rsel | output | 3 | Second multiplexer select, returned signal choice |
| status_req | output | 1 | One-cycle status-check request |
| cmd_err | output | 1 | One-cycle rejected-command flag |

## Verification
The pulse left by one byte falls in the same cycle in which the next byte is sampled. The bench therefore sends strobes back to back, for example status, then configuration, then a rejected byte, then status again. It checks that each pulse clears while the controls take or hold the new value. The bench also raises reset in the same cycle as a configuration strobe. It expects all-zero controls, with no pulse, from its cycle-by-cycle model.

// File: rtl/ctl_byte_decoder_pkg.sv
package ctl_byte_decoder_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam logic [CMD_W-1:0] CMD_OFFSET = 8'hA9;
  localparam logic [CMD_W-1:0] STATUS_CODE = 8'h01;
  localparam int unsigned N_CFG    = 6;
  localparam logic [CMD_W-1:0] CFG_CODES [N_CFG] = '{8'h10, 8'h12, 8'h13, 8'h24, 8'h26, 8'h27};

  localparam int unsigned PWR_W = 2;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PWR_LO = 4;
  localparam int unsigned FSEL_LO = 0;
  localparam int unsigned RSEL_HI_A = 7;
  localparam int unsigned RSEL_HI_B = 6;
  localparam int unsigned RSEL_LO_C = 3;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_STATUS = 2'd1,
    K_CONFIG = 2'd2,
    K_BAD    = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic [PWR_W-1:0] pwr;
    logic [SEL_W-1:0] fsel;
    logic [SEL_W-1:0] rsel;
  } ctl_fields_t;
endpackage

// File: rtl/ctl_byte_classify.sv
module ctl_byte_classify
  import ctl_byte_decoder_pkg::*;
#(
  parameter logic [CMD_W-1:0] OFFSET = CMD_OFFSET
) (
  input  logic             valid,
  input  logic [CMD_W-1:0] byte_in,
  output logic [CMD_W-1:0] diff,
  output cmd_kind_e        kind
);
  logic [N_CFG-1:0] cfg_hit;

  assign diff = byte_in - OFFSET;

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg_cmp
    assign cfg_hit[g] = (diff == CFG_CODES[g]);
  end

  always_comb begin
    if (!valid)                   kind = K_NONE;
    else if (diff == STATUS_CODE) kind = K_STATUS;
    else if (|cfg_hit)            kind = K_CONFIG;
    else                          kind = K_BAD;
  end
endmodule

// File: rtl/ctl_field_split.sv
module ctl_field_split
  import ctl_byte_decoder_pkg::*;
(
  input  logic [CMD_W-1:0] diff,
  output ctl_fields_t      fields
);
  always_comb begin
    fields.pwr  = diff[PWR_LO +: PWR_W];
    fields.fsel = diff[FSEL_LO +: SEL_W];
    fields.rsel = {diff[RSEL_HI_A], diff[RSEL_HI_B], diff[RSEL_LO_C]};
  end
endmodule

// File: rtl/ctl_state_regs.sv
module ctl_state_regs
  import ctl_byte_decoder_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  cmd_kind_e   kind,
  input  ctl_fields_t next_fields,
  output ctl_fields_t cur_fields,
  output logic        status_pulse,
  output logic        err_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_fields   <= '0;
      status_pulse <= 1'b0;
      err_pulse    <= 1'b0;
    end else begin
      status_pulse <= 1'b0;
      err_pulse    <= 1'b0;
      case (kind)
        K_STATUS: status_pulse <= 1'b1;
        K_CONFIG: cur_fields   <= next_fields;
        K_BAD:    err_pulse    <= 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_byte_decoder.sv
module ctl_byte_decoder
  import ctl_byte_decoder_pkg::*;
#(
  parameter logic [CMD_W-1:0] OFFSET = CMD_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  output logic [PWR_W-1:0] pll_pwr,
  output logic [SEL_W-1:0] fsel,
  output logic [SEL_W-1:0] rsel,
  output logic             status_req,
  output logic             cmd_err
);
  logic [CMD_W-1:0] diff;
  cmd_kind_e        kind;
  ctl_fields_t      next_fields;
  ctl_fields_t      cur_fields;

  ctl_byte_classify #(.OFFSET(OFFSET)) u_classify (
    .valid   (cmd_valid),
    .byte_in (cmd_byte),
    .diff    (diff),
    .kind    (kind)
  );

  ctl_field_split u_split (
    .diff   (diff),
    .fields (next_fields)
  );

  ctl_state_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .kind         (kind),
    .next_fields  (next_fields),
    .cur_fields   (cur_fields),
    .status_pulse (status_req),
    .err_pulse    (cmd_err)
  );

  assign pll_pwr = cur_fields.pwr;
  assign fsel    = cur_fields.fsel;
  assign rsel    = cur_fields.rsel;
endmodule

// File: rtl/ctl_byte_decoder_chk.sv
module ctl_byte_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic [1:0] pll_pwr,
  input logic [2:0] fsel,
  input logic [2:0] rsel,
  input logic       status_req,
  input logic       cmd_err
);
  logic [7:0] c_d;
  logic       c_cfg;
  logic       c_stat;
  assign c_d    = cmd_byte - 8'hA9;
  assign c_cfg  = c_d inside {8'h10, 8'h12, 8'h13, 8'h24, 8'h26, 8'h27};
  assign c_stat = (cmd_byte == 8'hAA);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pll_pwr == 2'b0 && fsel == 3'b0 && rsel == 3'b0 && !status_req && !cmd_err));

  a_r2_pwr_load: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c_cfg) |=> (pll_pwr == $past(c_d[5:4])));

  a_r3_fsel_load: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c_cfg) |=> (fsel == $past(c_d[2:0])));

  a_r4_rsel_load: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c_cfg) |=> (rsel == {$past(c_d[7]), $past(c_d[6]), $past(c_d[3])}));

  a_r5_status_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && c_stat) |=> (status_req && $stable(pll_pwr) && $stable(fsel) && $stable(rsel)));

  a_r6_err_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !c_stat && !c_cfg) |=> (cmd_err && $stable(pll_pwr) && $stable(fsel) && $stable(rsel)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!status_req && !cmd_err && $stable(pll_pwr) && $stable(fsel) && $stable(rsel)));

  a_r8_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    !(status_req && cmd_err));
endmodule

bind ctl_byte_decoder ctl_byte_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .pll_pwr    (pll_pwr),
  .fsel       (fsel),
  .rsel       (rsel),
  .status_req (status_req),
  .cmd_err    (cmd_err)
);

// File: tb/ctl_byte_decoder_tb_top.sv
module ctl_byte_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [1:0] pll_pwr;
  logic [2:0] fsel;
  logic [2:0] rsel;
  logic       status_req;
  logic       cmd_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  int e_pwr = 0, e_fsel = 0, e_rsel = 0, e_stat = 0, e_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_byte_decoder dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pll_pwr(pll_pwr), .fsel(fsel), .rsel(rsel),
    .status_req(status_req), .cmd_err(cmd_err)
  );

  // Behavioural reference model, updated on each rising edge.
  always @(posedge clk) begin
    int d;
    d = (int'(cmd_byte) + 256 - 169) % 256;
    e_stat <= 0;
    e_err  <= 0;
    if (rst) begin
      e_pwr <= 0; e_fsel <= 0; e_rsel <= 0;
    end else if (cmd_valid) begin
      if (d == 1) e_stat <= 1;
      else if (d == 16 || d == 18 || d == 19 || d == 36 || d == 38 || d == 39) begin
        e_pwr  <= (d / 16) % 4;
        e_fsel <= d % 8;
        e_rsel <= ((d / 128) % 2) * 4 + ((d / 64) % 2) * 2 + ((d / 8) % 2);
      end else e_err <= 1;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag == "R1" ? "R1" : (tag == "" ? "R2" : tag), "pll_pwr R2", int'(pll_pwr), e_pwr);
    chk(tag == "" ? "R3" : tag, "fsel R3", int'(fsel), e_fsel);
    chk(tag == "" ? "R4" : tag, "rsel R4", int'(rsel), e_rsel);
    chk(tag == "" ? "R5" : tag, "status_req R5", int'(status_req), e_stat);
    chk(tag == "" ? "R6" : tag, "cmd_err R6", int'(cmd_err), e_err);
    chk(tag == "" ? "R8" : tag, "pulse exclusive R8", int'(status_req && cmd_err), 0);
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(string t, bit v, logic [7:0] b, bit r);
    @(negedge clk);
    compare_all();
    tag = t;
    rst = r;
    cmd_valid = v;
    cmd_byte = b;
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5A;
    step("R1", 0, 8'h00, 1);
    step("R1", 0, 8'h00, 1);
    step("R1", 0, 8'h00, 0);
    step("R5", 1, 8'hAA, 0);   // status
    step("R2", 1, 8'hB9, 0);   // 300 MHz
    step("R7", 0, 8'hCD, 0);   // idle with a config byte on the bus
    step("R3", 1, 8'hBB, 0);
    step("R3", 1, 8'hBC, 0);
    step("R2", 1, 8'hCD, 0);
    step("R3", 1, 8'hCF, 0);
    step("R3", 1, 8'hD0, 0);
    step("R5", 1, 8'hAA, 0);   // status right after config
    step("R9", 1, 8'h00, 0);   // wraps to 0x57
    step("R9", 1, 8'hA9, 0);   // diff 0x00
    step("R9", 1, 8'hA8, 0);   // diff 0xFF
    step("R6", 1, 8'hFF, 0);
    step("R8", 1, 8'hAA, 0);   // err then status back to back
    step("R4", 1, 8'hB9, 0);
    step("R7", 0, 8'h00, 0);
    step("R6", 1, 8'hBA, 0);   // diff 0x11, rejected
    step("R10", 1, 8'hCD, 1);  // reset with strobe
    step("R10", 0, 8'h00, 0);
    step("R2", 1, 8'hD0, 0);
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0]) step("", 1, (lfsr[1] ? 8'hA9 + {5'b0, lfsr[4:2]} + {2'b0, lfsr[7:5], 3'b0} : lfsr), 0);
      else         step("R7", 0, lfsr, 0);
    end
    step("", 0, 8'h00, 0);
    step("", 0, 8'h00, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule